// File: doc/BRIEF.md
# Asynchronous SRAM strobe sequencer

This block sits between a synchronous host and a 128K x 8 asynchronous static RAM with one common data bus. The host raises a one-cycle (or held) request together with a write flag, a 17-bit address and a byte of write data. The controller then plays out the chip-select, write-strobe and output-enable sequence the memory needs, and reports completion with a one-cycle done pulse. On a read, the returned byte is registered and held until the next read completes.

Every phase length is a parameter. Each one is worked out at elaboration time from a picosecond timing set and the clock period, so a new speed grade or clock only needs new parameter values. Bus turnaround is designed so that it cannot cause contention. The controller never drives the data bus while the memory's output enable is active. It also keeps the output enable inactive for the memory's worst-case release time before it starts driving. While no access is running, the memory is deselected so that it sits in its low-power standby state.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access running: the selects are inactive (`mem_cs_n_o`=1, `mem_cs_o`=0), `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0, `busy_o`=0, `done_o`=0. `rdata_o` resets to 0.
- R2: A request that is high at a rising edge while the block is idle is accepted. `busy_o` is high from the next cycle up to and including the done cycle.
- R3: A write runs in this order. First come SU setup cycles, with the selects active, `mem_we_n_o` high and the bus not driven. Next come PW cycles with `mem_we_n_o` low and `mem_dq_oe_o` high. Then comes one hold cycle with `mem_we_n_o` high and the data still driven. Last comes the done cycle, in which the memory is deselected. `mem_oe_n_o` stays high throughout.
- R4: Each base count is ceil(time / clock period), with a minimum of 1. SU is the count for the bus release time. PW is the largest of: the count for the strobe width, the count for the data setup, (the select-to-end count − SU), and (the write cycle count − SU − 1). With the default parameters, SU=3, PW=6 and RA=7.
- R5: A read holds the selects active, `mem_we_n_o` high and `mem_oe_n_o` low for RA cycles, where RA is the larger of the address-access count and the output-enable access count. The data is sampled at the final edge of that window and appears on `rdata_o` in the done cycle.
- R6: `mem_dq_oe_o` is never high while `mem_oe_n_o` is low. It rises only after `mem_oe_n_o` has been high for at least SU cycles.
- R7: `mem_addr_o` is constant for as long as the memory is selected, and `mem_dq_o` is constant for as long as it is driven. Both equal the values captured when the request was accepted.
- R8: `done_o` is high for exactly one cycle. That cycle directly follows the last strobe phase.
- R9: A request that arrives while `busy_o` is high, including in the done cycle, is ignored. It leaves the memory contents unchanged.
- R10: The write flag sampled with the request selects the operation: 1 for a write, 0 for a read. A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read, sampled with the request |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Last read result, held |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_n_o | output | 1 | Active-low memory select |
| mem_cs_o | output | 1 | Active-high memory select |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data returned by the memory |

## Verification
The hardest case to reach is a write that starts as early as it possibly can after a read. Here the output enable has only just gone inactive, and the release margin is at its tightest. The bench reaches this case by raising the next write request in the same cycle as the read's done pulse and holding it for two cycles. That request is refused during done and accepted in the following idle cycle. The bench's memory model returns a poison value until the read window has run its full length, so a shortened read phase shows up as wrong data. Requests raised during the strobe phases and in the done cycle are followed by read-backs, which prove that those requests changed nothing.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and elaboration-time helpers that turn
// picosecond timing figures into whole clock-cycle phase counts.
package sram_seq_pkg;

    // Sequencer states. IDLE keeps the memory deselected (standby).
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_RD_ACCESS = 3'd4,
        ST_DONE      = 3'd5
    } seq_state_t;

    // Round a time span up to whole clock cycles, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned span_ps,
                                                 input int unsigned clk_ps);
        int unsigned n;
        n = (span_ps + clk_ps - 1) / clk_ps;
        if (n == 0) n = 1;
        return n;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Difference of two counts, floored at one cycle.
    function automatic int unsigned sub_min1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Module: sram_phase_timer
// Down-counter that measures the length of one strobe phase.
// Assumes: load_i is pulsed on the edge that enters a phase, and load_val_i
// is at least 1. phase_end_o is high in the last cycle of the phase.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             phase_end_o
);

    logic [CNT_W-1:0] remain_q;

    // Load the phase length on entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // The cycle holding a count of one is the phase's final cycle.
    assign phase_end_o = (remain_q == CNT_W'(1));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Module: sram_seq_fsm
// Control sequencer for one read or write access at a time.
// Assumes: phase counts are at least 1, and the timer reports the end of the
// phase it was last loaded with. Requests outside IDLE are ignored.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned SU_CYC = 3,
    parameter int unsigned PW_CYC = 6,
    parameter int unsigned RA_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic             phase_end_i,
    output seq_state_t       state_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             accept_o,
    output logic             capture_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // State register, reset into deselected idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state, timer load and capture strobes.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    load_o   = 1'b1;
                    if (wr_i) begin
                        state_d    = ST_WR_SETUP;
                        load_val_o = CNT_W'(SU_CYC);
                    end else begin
                        state_d    = ST_RD_ACCESS;
                        load_val_o = CNT_W'(RA_CYC);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (phase_end_i) begin
                    state_d    = ST_WR_PULSE;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(PW_CYC);
                end
            end
            ST_WR_PULSE: begin
                if (phase_end_i) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_DONE;
            end
            ST_RD_ACCESS: begin
                if (phase_end_i) begin
                    state_d   = ST_DONE;
                    capture_o = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sram_bus_regs.sv
`timescale 1ns/1ps
// Module: sram_bus_regs
// Holding registers for the address, the write byte and the read result.
// Assumes: accept_i is pulsed only in idle, so the address and write data
// stay frozen for the whole access. capture_i marks the read sample edge.
module sram_bus_regs #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Freeze the request's address and data when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Register the memory's byte at the end of the read window, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture_i) begin
            rdata_q <= mem_dq_i;
        end
    end

    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
// Module: sram_seq_ctrl (top)
// Converts host read/write requests into timed select, write-strobe and
// output-enable sequences for an asynchronous 8-bit SRAM.
// Assumes: all timing figures are in picoseconds and describe the memory's
// worst case. The memory pins are decoded from registered state, so they
// change only just after a clock edge.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_WCYCLE_PS   = 70000,
    parameter int unsigned T_WPULSE_PS   = 55000,
    parameter int unsigned T_SELEND_PS   = 65000,
    parameter int unsigned T_DSETUP_PS   = 30000,
    parameter int unsigned T_ACCESS_PS   = 70000,
    parameter int unsigned T_OEACC_PS    = 35000,
    parameter int unsigned T_RELEASE_PS  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_cs_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Phase lengths in cycles, derived from the timing set.
    localparam int unsigned SU_CYC  = ps_to_cycles(T_RELEASE_PS, CLK_PERIOD_PS);
    localparam int unsigned PW_CYC  = max_u(
        max_u(ps_to_cycles(T_WPULSE_PS, CLK_PERIOD_PS),
              ps_to_cycles(T_DSETUP_PS, CLK_PERIOD_PS)),
        max_u(sub_min1(ps_to_cycles(T_SELEND_PS, CLK_PERIOD_PS), SU_CYC),
              sub_min1(ps_to_cycles(T_WCYCLE_PS, CLK_PERIOD_PS), SU_CYC + 1)));
    localparam int unsigned RA_CYC  = max_u(ps_to_cycles(T_ACCESS_PS, CLK_PERIOD_PS),
                                            ps_to_cycles(T_OEACC_PS, CLK_PERIOD_PS));
    localparam int unsigned MAX_CYC = max_u(max_u(SU_CYC, PW_CYC), RA_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_end;
    logic             accept;
    logic             capture;
    logic             sel;
    logic             we_n;
    logic             oe_n;
    logic             dq_oe;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tmr_load),
        .load_val_i  (tmr_val),
        .phase_end_o (tmr_end)
    );

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .SU_CYC (SU_CYC),
        .PW_CYC (PW_CYC),
        .RA_CYC (RA_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .wr_i        (wr_i),
        .phase_end_i (tmr_end),
        .state_o     (state),
        .load_o      (tmr_load),
        .load_val_o  (tmr_val),
        .accept_o    (accept),
        .capture_o   (capture)
    );

    sram_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .capture_i (capture),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .mem_dq_i  (mem_dq_i),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_dq_o),
        .rdata_o   (rdata_o)
    );

    // Decode the memory strobes from the sequencer state.
    always_comb begin
        sel   = 1'b0;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        case (state)
            ST_WR_SETUP: begin
                sel = 1'b1;
            end
            ST_WR_PULSE: begin
                sel   = 1'b1;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                sel   = 1'b1;
                dq_oe = 1'b1;
            end
            ST_RD_ACCESS: begin
                sel  = 1'b1;
                oe_n = 1'b0;
            end
            default: begin
                sel = 1'b0;
            end
        endcase
    end

    assign mem_cs_n_o  = ~sel;
    assign mem_cs_o    = sel;
    assign mem_we_n_o  = we_n;
    assign mem_oe_n_o  = oe_n;
    assign mem_dq_oe_o = dq_oe;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_DONE);

endmodule

// File: rtl/sram_seq_chk.sv
`timescale 1ns/1ps
// Module: sram_seq_chk
// Protocol checker bound to sram_seq_ctrl. It watches only the ports.
// Assumes: SU_CYC matches the controller's release-time count.
module sram_seq_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SU_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_cs_n_o,
    input logic              mem_cs_o,
    input logic              mem_we_n_o,
    input logic              mem_oe_n_o,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe_o
);

    logic [15:0] oe_hi_cnt;
    logic        selected;

    assign selected = ~mem_cs_n_o & mem_cs_o;

    // Count consecutive cycles with the output enable inactive (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hi_cnt <= '0;
        end else if (!mem_oe_n_o) begin
            oe_hi_cnt <= '0;
        end else if (oe_hi_cnt != 16'hFFFF) begin
            oe_hi_cnt <= oe_hi_cnt + 16'd1;
        end
    end

    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_cs_n_o && !mem_cs_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

    a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (mem_oe_n_o && mem_dq_oe_o && selected));

    a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o);

    a_r6_release_margin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (oe_hi_cnt >= 16'(SU_CYC)));

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && $past(selected)) |-> $stable(mem_addr_o));

    a_r7_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !selected));

endmodule

bind sram_seq_ctrl sram_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SU_CYC (SU_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_cs_o    (mem_cs_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural memory plus a cycle-count reference model, with every
// output compared at each falling edge.
module sram_seq_ctrl_tb_top;

    localparam int PER_PS = 10000;

    function automatic int cyc(input int t_ps);
        int n;
        n = (t_ps + PER_PS - 1) / PER_PS;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SU = cyc(25000);
    localparam int PW = imax(imax(cyc(55000), cyc(30000)),
                             imax(cyc(65000) - SU, cyc(70000) - SU - 1));
    localparam int RA = imax(cyc(70000), cyc(35000));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy, done;
    logic [16:0] m_addr;
    logic        m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe;
    logic [7:0]  m_dq_o;
    logic [7:0]  m_dq_i = 8'h00;

    sram_seq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req), .wr_i (wr),
        .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
        .busy_o (busy), .done_o (done), .mem_addr_o (m_addr),
        .mem_cs_n_o (m_cs_n), .mem_cs_o (m_cs), .mem_we_n_o (m_we_n),
        .mem_oe_n_o (m_oe_n), .mem_dq_o (m_dq_o), .mem_dq_oe_o (m_dq_oe),
        .mem_dq_i (m_dq_i)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural memory contents; unwritten words read as an address hash.
    logic [7:0] mem_m [int];

    function automatic logic [7:0] mem_rd(input int a);
        if (mem_m.exists(a)) return mem_m[a];
        return 8'(a ^ (a >> 8)) ^ 8'h5A;
    endfunction

    // Memory model: poisoned output until the read window is long enough;
    // writes commit when the strobe returns high.
    int         rd_cnt = 0;
    bit         wpend = 0;
    int         wpend_a = 0;
    logic [7:0] wpend_d = 8'h00;
    always @(negedge clk) begin
        if (!m_cs_n && m_cs && m_we_n && !m_oe_n) rd_cnt = rd_cnt + 1;
        else rd_cnt = 0;
        m_dq_i = (rd_cnt >= RA) ? mem_rd(int'(m_addr)) : 8'hEE;
        if (!m_cs_n && m_cs && !m_we_n && m_dq_oe) begin
            wpend = 1; wpend_a = int'(m_addr); wpend_d = m_dq_o;
        end else if (wpend && m_we_n) begin
            mem_m[wpend_a] = wpend_d;
            wpend = 0;
        end
    end

    // Reference model: cycle index k within the current access (0 = idle).
    int          k = 0;
    bit          op_wr = 0;
    logic [16:0] op_a = '0;
    logic [7:0]  op_d = '0;
    logic [7:0]  rd_exp = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; rd_exp = '0;
        end else if (k == 0) begin
            if (req) begin
                k = 1; op_wr = wr; op_a = addr; op_d = wdata;
            end
        end else begin
            k = k + 1;
            if (!op_wr && k == RA + 1) rd_exp = mem_rd(int'(op_a));
            if (k > (op_wr ? SU + PW + 2 : RA + 1)) k = 0;
        end
    end

    // Per-cycle comparison against the model.
    bit    e_sel, e_we_n, e_oe_n, e_dqoe, e_done, e_busy;
    string tg;
    int    wlow_run = 0, oelow_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            e_busy = (k != 0);
            e_done = op_wr ? (k == SU + PW + 2) : (k == RA + 1);
            e_sel  = e_busy && !e_done;
            e_we_n = !(op_wr && k > SU && k <= SU + PW);
            e_dqoe = op_wr && k > SU && k <= SU + PW + 1;
            e_oe_n = !(!op_wr && e_sel);
            tg     = (k == 0) ? "R1" : (op_wr ? "R3" : "R5");
            chk(busy == e_busy, "R2 busy", busy, e_busy);
            chk(done == e_done, "R8 done", done, e_done);
            chk(m_cs_n == !e_sel, {tg, " cs_n"}, m_cs_n, !e_sel);
            chk(m_cs == e_sel, {tg, " cs"}, m_cs, e_sel);
            chk(m_we_n == e_we_n, {tg, " we_n"}, m_we_n, e_we_n);
            chk(m_oe_n == e_oe_n, {tg, " oe_n"}, m_oe_n, e_oe_n);
            chk(m_dq_oe == e_dqoe, {tg, " dq_oe"}, m_dq_oe, e_dqoe);
            if (e_sel) chk(m_addr == op_a, "R7 addr", m_addr, op_a);
            if (e_dqoe) chk(m_dq_o == op_d, "R7 wdata", m_dq_o, op_d);
            chk(rdata == rd_exp, "R5 rdata", rdata, rd_exp);
            chk(!(m_dq_oe && !m_oe_n), "R6 contention", m_dq_oe, 0);
            // R4: measured strobe and read window lengths
            if (!m_we_n) wlow_run++;
            else if (wlow_run > 0) begin
                chk(wlow_run == PW, "R4 pulse cycles", wlow_run, PW); wlow_run = 0;
            end
            if (!m_oe_n) oelow_run++;
            else if (oelow_run > 0) begin
                chk(oelow_run == RA, "R4 read cycles", oelow_run, RA); oelow_run = 0;
            end
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    endtask

    task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
        chk(m_cs_n && !m_cs && m_we_n && m_oe_n && !m_dq_oe, "R1 reset strobes",
            {m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe}, 5'b10110);
        chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: writes and reads at both address extremes and an untouched word
        do_op(1, 17'h00000, 8'h11);
        do_op(1, 17'h1FFFF, 8'hFE);
        do_op(0, 17'h00000, 8'h00);
        chk(rdata == 8'h11, "R10 read low addr", rdata, 8'h11);
        do_op(0, 17'h1FFFF, 8'h00);
        chk(rdata == 8'hFE, "R10 read high addr", rdata, 8'hFE);
        do_op(0, 17'h00123, 8'h00);
        chk(rdata == mem_rd(17'h00123), "R5 untouched word", rdata, mem_rd(17'h00123));

        // R9: requests during busy and in the done cycle are ignored
        do_op(1, 17'h00400, 8'h55);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 17'h00800; wdata = 8'h33;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        req = 1'b1; addr = 17'h00400; wdata = 8'h77;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        req = 1'b1; addr = 17'h00400; wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 0, "R9 done-cycle request refused", busy, 0);
        do_op(0, 17'h00400, 8'h00);
        chk(rdata == 8'h55, "R9 ignored writes left data", rdata, 8'h55);

        // R6: write requested in the done cycle of a read, accepted at idle
        do_op(0, 17'h00800, 8'h00);
        chk(rdata == 8'h33, "R10 read after write", rdata, 8'h33);
        req = 1'b1; wr = 1'b1; addr = 17'h00801; wdata = 8'h3C;
        @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        wait_done();
        do_op(0, 17'h00801, 8'h00);
        chk(rdata == 8'h3C, "R6 write right after read", rdata, 8'h3C);

        // R2: request held high gives back-to-back reads
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 17'h1FFFF;
        repeat (3 * (RA + 2) + 1) @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);

        // R10: spread of addresses and data patterns
        for (int i = 0; i < 24; i++)
            do_op(1, 17'((i * 4099 + 7) & 17'h1FFFF), 8'((i * 37) ^ 8'hC3));
        for (int i = 0; i < 24; i++) begin
            do_op(0, 17'((i * 4099 + 7) & 17'h1FFFF), 8'h00);
            chk(rdata == 8'((i * 37) ^ 8'hC3), "R10 pattern read", rdata,
                8'((i * 37) ^ 8'hC3));
        end

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule